// File: doc/BRIEF.md
# Descending Call and Data Stack

This block is a small, dedicated last-in-first-out store for a simple processor core. A controller issues one request per cycle. Each request carries a 2-bit operation code. Two kinds of traffic share the same storage. Explicit data requests push a supplied word or pop the top word back out. Implicit subroutine requests save the next-instruction address on a call and hand it back on a return. Because both kinds share one stack, a return must be matched with the call that made it, in strict nesting order with the data words.

The stack grows toward lower indices. A stack pointer always names the most recently stored entry. When the stack is empty, the pointer sits one past the highest index. A store first moves the pointer down and then writes at the new position. A removal first reads at the pointer and then moves it up. Requests that would overrun either end are refused and flagged. Every request finishes in one clock cycle. A removed word appears on a registered output one cycle after the request, together with a one-cycle valid strobe. Data words and restored addresses have separate strobes.

Top module: `lifo_callstack`

## Requirements
- R1: After reset `sp` equals DEPTH (8), `empty` is 1, and `full`, `err`, `pop_valid` and `ret_valid` are 0. `pop_data` and `ret_pc` are 0.
- R2: Op code 2'b00 (data store) with room left lowers `sp` by one in the next cycle and writes `req_data` at the new `sp` position.
- R3: Op code 2'b01 (data fetch) on a non-empty stack drives the entry at `sp` onto `pop_data` in the next cycle. `pop_valid` is high for that one cycle and `sp` rises by one.
- R4: Op code 2'b10 (call) with room left stores `next_pc` exactly as R2 stores a data word.
- R5: Op code 2'b11 (return) on a non-empty stack drives the entry at `sp` onto `ret_pc` in the next cycle. `ret_valid` is high for that one cycle, `sp` rises by one, and `pop_valid` stays low.
- R6: Data words and saved addresses share one store in strict LIFO order. Each removal returns the most recent entry that has not yet been removed, whichever op code stored it.
- R7: `full` is 1 exactly when `sp` is 0. `empty` is 1 exactly when `sp` equals DEPTH. `sp` never exceeds DEPTH.
- R8: A store or call while `full` is refused. `sp` and all entries are left unchanged, and `err` is high for the following cycle.
- R9: A fetch or return while `empty` is refused. `sp` is left unchanged, neither strobe rises, and `err` is high for the following cycle.
- R10: A cycle with `req_valid` low changes nothing. `sp` keeps its value, `pop_data` and `ret_pc` hold their values, and `err`, `pop_valid` and `ret_valid` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | Operation: 00 store, 01 fetch, 10 call, 11 return |
| req_data | input | WORD_W | Word to store on a data store |
| next_pc | input | WORD_W | Next-instruction address saved on a call |
| pop_data | output | WORD_W | Last word fetched (registered) |
| pop_valid | output | 1 | One-cycle strobe for a new `pop_data` |
| ret_pc | output | WORD_W | Last address restored (registered) |
| ret_valid | output | 1 | One-cycle strobe for a new `ret_pc` |
| sp | output | $clog2(DEPTH+1) | Current stack pointer |
| full | output | 1 | No free entry remains |
| empty | output | 1 | No entry is stored |
| err | output | 1 | One-cycle pulse after a refused request |

## Verification
The hardest case to reach is a refused request at either end while the stack already holds mixed data words and saved addresses. Reaching it takes an exact run of accepted stores or removals first. Directed sequences fill the stack to the brim and drain it to the bottom, then retry at each end. Draining the stack afterwards shows that the refused store left every entry intact. A random walk over all four op codes, with idle cycles mixed in, then crosses both boundaries many times. It also interleaves calls and returns with data traffic, so returns pop data words and fetches pop saved addresses.

// File: rtl/lifo_callstack_pkg.sv
package lifo_callstack_pkg;

    typedef enum logic [1:0] {
        OP_PUSH = 2'b00,
        OP_POP  = 2'b01,
        OP_CALL = 2'b10,
        OP_RET  = 2'b11
    } lcs_op_e;

    function automatic logic op_stores(input lcs_op_e op);
        return (op == OP_PUSH) || (op == OP_CALL);
    endfunction

    function automatic logic op_removes(input lcs_op_e op);
        return (op == OP_POP) || (op == OP_RET);
    endfunction

endpackage

// File: rtl/lcs_ptr.sv
module lcs_ptr
    import lifo_callstack_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int SP_W  = $clog2(DEPTH + 1),
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  lcs_op_e          req_op,
    output logic [SP_W-1:0]  sp_q,
    output logic             full,
    output logic             empty,
    output logic             push_ok,
    output logic             pop_ok,
    output logic [IDX_W-1:0] wr_idx,
    output logic [IDX_W-1:0] rd_idx,
    output logic             err_q
);

    localparam logic [SP_W-1:0] SP_EMPTY = SP_W'(DEPTH);

    typedef struct packed {
        logic [SP_W-1:0] sp;
        logic            err;
    } ptr_state_t;

    ptr_state_t st_d, st_q;
    logic       want_push, want_pop;

    always_comb begin
        want_push = req_valid && op_stores(req_op);
        want_pop  = req_valid && op_removes(req_op);
        full      = (st_q.sp == '0);
        empty     = (st_q.sp == SP_EMPTY);
        push_ok   = want_push && !full;
        pop_ok    = want_pop && !empty;
        wr_idx    = IDX_W'(st_q.sp - SP_W'(1));
        rd_idx    = IDX_W'(st_q.sp);

        st_d      = st_q;
        st_d.err  = (want_push && full) || (want_pop && empty);
        if (push_ok) begin
            st_d.sp = st_q.sp - SP_W'(1);
        end else if (pop_ok) begin
            st_d.sp = st_q.sp + SP_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sp  <= SP_EMPTY;
            st_q.err <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sp_q  = st_q.sp;
    assign err_q = st_q.err;

    AST_SP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        sp_q <= SP_EMPTY); // R7

    AST_PUSH_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        push_ok |=> (sp_q == $past(sp_q) - SP_W'(1)) && !err_q); // R2

    AST_POP_INC: assert property (@(posedge clk) disable iff (!rst_n)
        pop_ok |=> (sp_q == $past(sp_q) + SP_W'(1)) && !err_q); // R3

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (want_push && full) |=> (sp_q == '0) && err_q); // R8

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (want_pop && empty) |=> (sp_q == SP_EMPTY) && err_q); // R9

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(sp_q) && !err_q); // R10

endmodule

// File: rtl/lcs_store.sv
module lcs_store #(
    parameter int DEPTH  = 8,
    parameter int WORD_W = 16,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_data
);

    logic [WORD_W-1:0] entry_q [DEPTH];
    logic [WORD_W-1:0] entry_d [DEPTH];

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
        always_comb begin
            entry_d[gi] = entry_q[gi];
            if (wr_en && (wr_idx == IDX_W'(gi))) begin
                entry_d[gi] = wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                entry_q[gi] <= '0;
            end else begin
                entry_q[gi] <= entry_d[gi];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (rd_idx == IDX_W'(k)) begin
                rd_data = entry_q[k];
            end
        end
    end

    AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_idx) < DEPTH)); // R2

endmodule

// File: rtl/lifo_callstack.sv
module lifo_callstack
    import lifo_callstack_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int WORD_W = 16,
    localparam int SP_W  = $clog2(DEPTH + 1),
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [WORD_W-1:0] req_data,
    input  logic [WORD_W-1:0] next_pc,
    output logic [WORD_W-1:0] pop_data,
    output logic              pop_valid,
    output logic [WORD_W-1:0] ret_pc,
    output logic              ret_valid,
    output logic [SP_W-1:0]   sp,
    output logic              full,
    output logic              empty,
    output logic              err
);

    typedef struct packed {
        logic [WORD_W-1:0] pop_data;
        logic              pop_valid;
        logic [WORD_W-1:0] ret_pc;
        logic              ret_valid;
    } out_state_t;

    lcs_op_e           op;
    logic              push_ok, pop_ok;
    logic [IDX_W-1:0]  wr_idx, rd_idx;
    logic [WORD_W-1:0] push_word, stk_rd_data;
    out_state_t        out_d, out_q;

    assign op        = lcs_op_e'(req_op);
    assign push_word = (op == OP_CALL) ? next_pc : req_data;

    lcs_ptr #(.DEPTH(DEPTH)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_op    (op),
        .sp_q      (sp),
        .full      (full),
        .empty     (empty),
        .push_ok   (push_ok),
        .pop_ok    (pop_ok),
        .wr_idx    (wr_idx),
        .rd_idx    (rd_idx),
        .err_q     (err)
    );

    lcs_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (push_ok),
        .wr_idx  (wr_idx),
        .wr_data (push_word),
        .rd_idx  (rd_idx),
        .rd_data (stk_rd_data)
    );

    always_comb begin
        out_d           = out_q;
        out_d.pop_valid = 1'b0;
        out_d.ret_valid = 1'b0;
        if (pop_ok) begin
            if (op == OP_RET) begin
                out_d.ret_pc    = stk_rd_data;
                out_d.ret_valid = 1'b1;
            end else begin
                out_d.pop_data  = stk_rd_data;
                out_d.pop_valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign pop_data  = out_q.pop_data;
    assign pop_valid = out_q.pop_valid;
    assign ret_pc    = out_q.ret_pc;
    assign ret_valid = out_q.ret_valid;

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(pop_valid && ret_valid)); // R5

    AST_TOP_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
        push_ok |=> (stk_rd_data == $past(push_word))); // R2

    AST_STROBE_NEEDS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && op_removes(op) && empty) |=> !pop_valid && !ret_valid); // R9

    AST_LIFO_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(push_ok, 2) && $past(pop_ok)) |->
            ((pop_valid && pop_data == $past(push_word, 2)) ||
             (ret_valid && ret_pc == $past(push_word, 2)))); // R6

    AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !pop_valid |-> $stable(pop_data)); // R10

endmodule

// File: tb/lifo_callstack_bench.sv
`timescale 1ns/1ps
module lifo_callstack_bench;
    import lifo_callstack_pkg::*;

    localparam int DEPTH  = 8;
    localparam int WORD_W = 16;
    localparam int SP_W   = $clog2(DEPTH + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [1:0]        req_op = 2'b00;
    logic [WORD_W-1:0] req_data = '0;
    logic [WORD_W-1:0] next_pc = '0;
    logic [WORD_W-1:0] pop_data, ret_pc;
    logic              pop_valid, ret_valid, full, empty, err;
    logic [SP_W-1:0]   sp;

    int unsigned vectors = 0;
    int unsigned fails   = 0;
    bit          done    = 1'b0;

    logic [WORD_W-1:0] m_mem [DEPTH];
    int                m_sp;
    logic [WORD_W-1:0] m_pd, m_rpc;

    always #2 clk = ~clk;

    lifo_callstack #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_lifo_callstack (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_data(req_data), .next_pc(next_pc), .pop_data(pop_data),
        .pop_valid(pop_valid), .ret_pc(ret_pc), .ret_valid(ret_valid),
        .sp(sp), .full(full), .empty(empty), .err(err)
    );

    function automatic string tag_of(input logic v, input logic [1:0] op);
        if (!v) return "R10";
        case (op)
            2'b00:   return "R2";
            2'b01:   return "R3";
            2'b10:   return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
        end
    endtask

    task automatic compare(input string tag, input bit e_err,
                           input bit e_pv, input bit e_rv);
        chk(tag, "sp", 32'(sp), 32'(m_sp));
        chk("R7", "full", 32'(full), 32'(m_sp == 0));
        chk("R7", "empty", 32'(empty), 32'(m_sp == DEPTH));
        chk(tag, "err", 32'(err), 32'(e_err));
        chk(tag, "pop_valid", 32'(pop_valid), 32'(e_pv));
        chk(tag, "ret_valid", 32'(ret_valid), 32'(e_rv));
        chk(tag, "pop_data", 32'(pop_data), 32'(m_pd));
        chk(tag, "ret_pc", 32'(ret_pc), 32'(m_rpc));
    endtask

    // Called at a falling edge; returns at the next falling edge after checking.
    task automatic req(input logic v, input logic [1:0] op,
                       input logic [WORD_W-1:0] d, input logic [WORD_W-1:0] pc,
                       input string tag_over = "");
        bit    e_err = 0, e_pv = 0, e_rv = 0;
        string tag;
        tag = (tag_over != "") ? tag_over : tag_of(v, op);
        req_valid = v; req_op = op; req_data = d; next_pc = pc;
        if (v && (op == 2'b00 || op == 2'b10)) begin
            if (m_sp == 0) begin
                e_err = 1;
                if (tag_over == "") tag = "R8";
            end else begin
                m_sp--;
                m_mem[m_sp] = (op == 2'b10) ? pc : d;
            end
        end else if (v) begin
            if (m_sp == DEPTH) begin
                e_err = 1;
                if (tag_over == "") tag = "R9";
            end else begin
                if (op == 2'b11) begin m_rpc = m_mem[m_sp]; e_rv = 1; end
                else             begin m_pd  = m_mem[m_sp]; e_pv = 1; end
                m_sp++;
            end
        end
        @(negedge clk);
        compare(tag, e_err, e_pv, e_rv);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
        m_sp = DEPTH; m_pd = '0; m_rpc = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        compare("R1", 0, 0, 0);

        // R9: removal on empty stack
        req(1, 2'b01, 16'h0, 16'h0);
        req(1, 2'b11, 16'h0, 16'h0);
        // R2 and R7: fill to the brim
        for (int i = 0; i < DEPTH; i++) req(1, 2'b00, 16'hA000 + 16'(i), 16'h0);
        // R8: store and call when full, contents kept
        req(1, 2'b00, 16'hDEAD, 16'h0);
        req(1, 2'b10, 16'h0, 16'hBEEF);
        // R10: idle cycles
        req(0, 2'b01, 16'h1234, 16'h5678);
        // R3 and R6: drain in reverse order, proves R8 left entries intact
        for (int i = 0; i < DEPTH; i++) req(1, 2'b01, 16'h0, 16'h0);
        req(1, 2'b01, 16'h0, 16'h0);
        req(0, 2'b00, 16'h0, 16'h0);
        // R4, R5, R6: nested calls around data
        req(1, 2'b00, 16'h0D01, 16'h0, "R6");
        req(1, 2'b10, 16'h0, 16'h0101);
        req(1, 2'b00, 16'h0D02, 16'h0, "R6");
        req(1, 2'b10, 16'h0, 16'h0202);
        req(1, 2'b11, 16'h0, 16'h0);
        req(1, 2'b01, 16'h0, 16'h0, "R6");
        req(1, 2'b11, 16'h0, 16'h0);
        req(1, 2'b01, 16'h0, 16'h0, "R6");
        // R6: a return pops a data word, a fetch pops a saved address
        req(1, 2'b00, 16'h7777, 16'h0);
        req(1, 2'b11, 16'h0, 16'h0, "R6");
        req(1, 2'b10, 16'h0, 16'h3C3C);
        req(1, 2'b01, 16'h0, 16'h0, "R6");

        // Random walk over all op codes with idle cycles
        for (int n = 0; n < 3000; n++) begin
            logic              v;
            logic [1:0]        op;
            v  = ($urandom % 8) != 0;
            op = 2'($urandom);
            req(v, op, 16'($urandom), 16'($urandom));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule